// File: doc/BRIEF.md
# I2S Half-Word Receiver

This block deserializes one I2S-style stereo stream. The bit clock, the word-select line and the serial data come from an external transmitter or master, and the block follows them. Each channel slot is 32 bit periods long, and the left (word-select low) and right (word-select high) slots alternate. The three bus lines are resynchronized into the system clock domain. Data are sampled on each rising bit-clock edge that is detected after resynchronization.

Received audio is handed to software as 16-bit half-words through a single data register with a ready flag. With 16-bit samples in a 32-bit slot, one half-word is delivered per slot as soon as its 16 most significant bits are in, and the padding is dropped. With 24-bit samples, two half-words are delivered. The first carries sample bits 23..16 and 15..8 of the slot MSB-first, that is slot bits 31..16. The second carries slot bits 15..8 in its upper byte. Two alignments are supported: MSB-justified, and the one-bit-delayed alignment of the Philips standard. A side bit tells which channel the held half-word belongs to. An overrun flag records a half-word that was lost because the previous one had not been read yet.

Top module: `i2s_hw_rx`

## Requirements
- R1: While `rst_n` is low, and on every clock while `cfg_en` is low, `rx_ready`, `rx_overrun` and `irq` are 0 and no half-word is accepted.
- R2: `lr_sel` and `ser_data` are sampled on rising edges of `bit_clk`. Each slot is 32 bit periods long and is received MSB first. A slot starts only at a level change of the sampled `lr_sel` seen after enable.
- R3: With `cfg_philips` = 0 (MSB-justified), the bit sampled at the edge where `lr_sel` changes is slot bit 31.
- R4: With `cfg_philips` = 1, the bit sampled at the edge where `lr_sel` changes is ignored, and slot bit 31 is the bit sampled one bit period later.
- R5: With `cfg_wide24` = 0, exactly one half-word per slot is delivered, equal to slot bits 31..16, once the 16th bit of the slot has been sampled. Slot bits 15..0 are never delivered.
- R6: With `cfg_wide24` = 1, two half-words per slot are delivered. The first equals slot bits 31..16. The second holds slot bits 15..8 in `rd_data[15:8]`, and its `rd_data[7:0]` has no defined value. Slot bits 7..0 are never delivered.
- R7: `rd_side` is 0 for a half-word from a slot with `lr_sel` low (left) and 1 for a slot with `lr_sel` high (right).
- R8: A delivered half-word sets `rx_ready` and appears on `rd_data`. A one-cycle `rd_strobe` while `rx_ready` is 1 clears `rx_ready` on the next clock.
- R9: A half-word that completes while `rx_ready` is 1 and `rd_strobe` is 0 is discarded. `rd_data` and `rd_side` keep the unread word, and `rx_overrun` is set and stays set until `cfg_en` goes low.
- R10: When a half-word completes in the same cycle as `rd_strobe`, the new word is loaded, `rx_ready` stays 1 and `rx_overrun` is not set.
- R11: `irq` is 1 exactly when `irq_en` is 1 and either `rx_ready` or `rx_overrun` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Receiver enable; low clears framing and flags |
| cfg_philips | input | 1 | Alignment: 0 MSB-justified, 1 one-bit delayed |
| cfg_wide24 | input | 1 | Sample size: 0 16-bit in 32-bit slot, 1 24-bit in 32-bit slot |
| irq_en | input | 1 | Interrupt enable |
| bit_clk | input | 1 | Serial bit clock from the bus |
| lr_sel | input | 1 | Word-select line: 0 left, 1 right |
| ser_data | input | 1 | Serial data line |
| rd_strobe | input | 1 | One-cycle read of the data register |
| rd_data | output | 16 | Held half-word |
| rd_side | output | 1 | Channel of the held half-word |
| rx_ready | output | 1 | A half-word is waiting to be read |
| rx_overrun | output | 1 | A half-word was lost |
| irq | output | 1 | Interrupt request |

## Verification
A half-word can complete in exactly the clock in which software reads the register that still holds the previous word. The two then compete for the ready flag and the overrun flag. The bench holds one word unread and lets the next one finish while it sweeps a single read pulse across a window of clocks around the bit-clock edge that completes the word. The offsets where the read lands at or before the completion must end with the new word held, the flag still set and no overrun. Every later offset must end with the old word kept, the flag cleared and the overrun latched.

// File: rtl/i2s_hw_pkg.sv
package i2s_hw_pkg;

  // Width of one delivered half-word.
  localparam int unsigned HW_W = 16;
  // Width of a wide sample; the second half-word carries its low part.
  localparam int unsigned WIDE_W = 24;
  localparam int unsigned LO_W = WIDE_W - HW_W;

  typedef enum logic {
    ALIGN_MSB     = 1'b0,
    ALIGN_DELAYED = 1'b1
  } align_e;

  typedef enum logic {
    FMT_NARROW = 1'b0,
    FMT_WIDE   = 1'b1
  } fmt_e;

  // True when the slot bit count just reached a delivery point.
  function automatic logic is_take(input int unsigned n, input logic wide);
    return (n == HW_W) || (wide && (n == WIDE_W));
  endfunction

  // Builds the half-word from the shift register contents.
  function automatic logic [HW_W-1:0] form_word(input logic [HW_W-1:0] sh,
                                                input logic second);
    if (second) return {sh[LO_W-1:0], {(HW_W-LO_W){1'b0}}};
    return sh;
  endfunction

endpackage

// File: rtl/i2s_hw_edge.sv
module i2s_hw_edge #(
  parameter int unsigned SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ck_in,
  input  logic ws_in,
  input  logic sd_in,
  output logic rise,
  output logic ws_s,
  output logic sd_s
);

  localparam int unsigned NSIG = 3;

  logic [NSIG-1:0] raw;
  logic [NSIG-1:0] synced;
  logic            ck_prev;

  assign raw = {ck_in, ws_in, sd_in};

  for (genvar g = 0; g < NSIG; g++) begin : g_sync
    logic [SYNC-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[SYNC-2:0], raw[g]};
    end
    assign synced[g] = chain[SYNC-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ck_prev <= 1'b0;
    else        ck_prev <= synced[2];
  end

  assign rise = synced[2] & ~ck_prev;
  assign ws_s = synced[1];
  assign sd_s = synced[0];

endmodule

// File: rtl/i2s_hw_slot.sv
module i2s_hw_slot
  import i2s_hw_pkg::*;
#(
  parameter int unsigned SLOT_BITS = 32,
  localparam int unsigned CNT_W = $clog2(SLOT_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  align_e           align,
  input  fmt_e             fmt,
  input  logic             rise,
  input  logic             ws,
  input  logic             sd,
  output logic             hw_valid,
  output logic [HW_W-1:0]  hw_data,
  output logic             hw_side,
  output logic [CNT_W-1:0] bit_cnt
);

  logic            seen;
  logic            armed;
  logic            ws_q;
  logic            slot_side;
  logic [HW_W-1:0] sh;
  logic [HW_W-1:0] sh_next;
  logic            wide;
  int unsigned     n_next;

  assign sh_next = {sh[HW_W-2:0], sd};
  assign wide    = (fmt == FMT_WIDE);
  assign n_next  = 32'(bit_cnt) + 32'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen      <= 1'b0;
      armed     <= 1'b0;
      ws_q      <= 1'b0;
      slot_side <= 1'b0;
      sh        <= '0;
      bit_cnt   <= '0;
      hw_valid  <= 1'b0;
      hw_data   <= '0;
      hw_side   <= 1'b0;
    end else if (!en) begin
      seen     <= 1'b0;
      armed    <= 1'b0;
      bit_cnt  <= '0;
      hw_valid <= 1'b0;
    end else begin
      hw_valid <= 1'b0;
      if (rise) begin
        seen <= 1'b1;
        ws_q <= ws;
        if (seen && (ws != ws_q)) begin
          // slot boundary
          armed     <= 1'b1;
          slot_side <= ws;
          if (align == ALIGN_DELAYED) begin
            bit_cnt <= '0;
          end else begin
            sh      <= sh_next;
            bit_cnt <= CNT_W'(1);
          end
        end else if (armed && (bit_cnt < CNT_W'(SLOT_BITS))) begin
          sh      <= sh_next;
          bit_cnt <= bit_cnt + CNT_W'(1);
          if (is_take(n_next, wide)) begin
            hw_valid <= 1'b1;
            hw_data  <= form_word(sh_next, n_next != HW_W);
            hw_side  <= slot_side;
          end
        end
      end
    end
  end

endmodule

// File: rtl/i2s_hw_dreg.sv
module i2s_hw_dreg
  import i2s_hw_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            hw_valid,
  input  logic [HW_W-1:0] hw_data,
  input  logic            hw_side,
  input  logic            rd_strobe,
  output logic [HW_W-1:0] data,
  output logic            side,
  output logic            ready,
  output logic            overrun
);

  logic accept;
  logic lost;

  assign accept = hw_valid && (!ready || rd_strobe);
  assign lost   = hw_valid && ready && !rd_strobe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data    <= '0;
      side    <= 1'b0;
      ready   <= 1'b0;
      overrun <= 1'b0;
    end else if (!en) begin
      ready   <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (accept) begin
        data  <= hw_data;
        side  <= hw_side;
        ready <= 1'b1;
      end else if (rd_strobe) begin
        ready <= 1'b0;
      end
      if (lost) overrun <= 1'b1;
    end
  end

endmodule

// File: rtl/i2s_hw_rx.sv
module i2s_hw_rx
  import i2s_hw_pkg::*;
#(
  parameter int unsigned SYNC      = 2,
  parameter int unsigned SLOT_BITS = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_en,
  input  logic            cfg_philips,
  input  logic            cfg_wide24,
  input  logic            irq_en,
  input  logic            bit_clk,
  input  logic            lr_sel,
  input  logic            ser_data,
  input  logic            rd_strobe,
  output logic [HW_W-1:0] rd_data,
  output logic            rd_side,
  output logic            rx_ready,
  output logic            rx_overrun,
  output logic            irq
);

  localparam int unsigned CNT_W = $clog2(SLOT_BITS + 1);

  // Internal events brought out for the checker.
  logic             ck_rise;
  logic             ws_s;
  logic             sd_s;
  logic             hw_valid;
  logic [HW_W-1:0]  hw_data;
  logic             hw_side;
  logic [CNT_W-1:0] bit_cnt;
  align_e           align;
  fmt_e             fmt;

  assign align = cfg_philips ? ALIGN_DELAYED : ALIGN_MSB;
  assign fmt   = cfg_wide24 ? FMT_WIDE : FMT_NARROW;

  i2s_hw_edge #(.SYNC(SYNC)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .ck_in (bit_clk),
    .ws_in (lr_sel),
    .sd_in (ser_data),
    .rise  (ck_rise),
    .ws_s  (ws_s),
    .sd_s  (sd_s)
  );

  i2s_hw_slot #(.SLOT_BITS(SLOT_BITS)) u_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (cfg_en),
    .align    (align),
    .fmt      (fmt),
    .rise     (ck_rise),
    .ws       (ws_s),
    .sd       (sd_s),
    .hw_valid (hw_valid),
    .hw_data  (hw_data),
    .hw_side  (hw_side),
    .bit_cnt  (bit_cnt)
  );

  i2s_hw_dreg u_dreg (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (cfg_en),
    .hw_valid  (hw_valid),
    .hw_data   (hw_data),
    .hw_side   (hw_side),
    .rd_strobe (rd_strobe),
    .data      (rd_data),
    .side      (rd_side),
    .ready     (rx_ready),
    .overrun   (rx_overrun)
  );

  assign irq = irq_en & (rx_ready | rx_overrun);

endmodule

// File: rtl/i2s_hw_rx_chk.sv
module i2s_hw_rx_chk
  import i2s_hw_pkg::*;
#(
  parameter int unsigned CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_en,
  input logic             cfg_wide24,
  input logic             rd_strobe,
  input logic             hw_valid,
  input logic [CNT_W-1:0] bit_cnt,
  input logic [HW_W-1:0]  rd_data,
  input logic             rx_ready,
  input logic             rx_overrun
);

  // R1: disabled receiver holds no flags
  p_idle_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> (!rx_ready && !rx_overrun));

  // R2: a completed half-word is a single-cycle event
  p_single_event_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hw_valid |=> !hw_valid);

  // R5 and R6: words complete only at the 16th or the 24th slot bit
  p_take_point_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hw_valid |-> ((bit_cnt == CNT_W'(HW_W)) ||
                  (cfg_wide24 && (bit_cnt == CNT_W'(WIDE_W)))));

  // R8: the ready flag rises only from a completed word
  p_ready_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ready) |-> $past(hw_valid));

  // R8: a read without a new word empties the register
  p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && rd_strobe && !hw_valid) |=> !rx_ready);

  // R9: a lost word sets overrun and leaves the held word alone
  p_overrun_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && rx_ready && hw_valid && !rd_strobe) |=>
      (rx_overrun && $stable(rd_data)));

  // R10: a read in the completion cycle keeps the flag and raises no overrun
  p_same_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && rd_strobe && hw_valid) |=> (rx_ready && !$rose(rx_overrun)));

endmodule

bind i2s_hw_rx i2s_hw_rx_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_en     (cfg_en),
  .cfg_wide24 (cfg_wide24),
  .rd_strobe  (rd_strobe),
  .hw_valid   (hw_valid),
  .bit_cnt    (bit_cnt),
  .rd_data    (rd_data),
  .rx_ready   (rx_ready),
  .rx_overrun (rx_overrun)
);

// File: tb/i2s_hw_rx_tb.sv
module i2s_hw_rx_tb;

  localparam int HALF = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_en = 1'b0;
  logic        cfg_philips = 1'b0;
  logic        cfg_wide24 = 1'b0;
  logic        irq_en = 1'b0;
  logic        bit_clk = 1'b0;
  logic        lr_sel = 1'b1;
  logic        ser_data = 1'b0;
  logic        rd_strobe = 1'b0;
  logic [15:0] rd_data;
  logic        rd_side;
  logic        rx_ready;
  logic        rx_overrun;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] exp_d [4];
  logic [15:0] exp_m [4];
  logic        exp_s [4];

  always #2 clk = ~clk;

  i2s_hw_rx u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_philips(cfg_philips),
    .cfg_wide24(cfg_wide24), .irq_en(irq_en), .bit_clk(bit_clk),
    .lr_sel(lr_sel), .ser_data(ser_data), .rd_strobe(rd_strobe),
    .rd_data(rd_data), .rd_side(rd_side), .rx_ready(rx_ready),
    .rx_overrun(rx_overrun), .irq(irq)
  );

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Stream layout with MSB-justified word select: 2 idle bits (right),
  // 32 left bits, 32 right bits.
  function automatic logic ws_msb(input int k);
    if (k < 2)  return 1'b1;
    if (k < 34) return 1'b0;
    if (k < 66) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic sd_at(input int k, input logic [31:0] l,
                                 input logic [31:0] r);
    if (k < 2)  return 1'b0;
    if (k < 34) return l[33-k];
    if (k < 66) return r[65-k];
    return 1'b0;
  endfunction

  task automatic send_bit(input logic w, input logic b, input int rd_at);
    @(negedge clk);
    bit_clk = 1'b0; lr_sel = w; ser_data = b;
    repeat (HALF - 1) @(negedge clk);
    @(negedge clk);
    bit_clk = 1'b1;
    if (rd_at >= 0) begin
      repeat (rd_at) @(negedge clk);
      rd_strobe = 1'b1;
      @(negedge clk);
      rd_strobe = 1'b0;
    end else begin
      repeat (HALF - 1) @(negedge clk);
    end
  endtask

  // Delayed alignment moves every word-select change one bit earlier.
  task automatic send_frame(input logic delayed, input logic [31:0] l,
                            input logic [31:0] r, input int spec_k,
                            input int d);
    for (int k = 0; k < 66; k++) begin
      send_bit(delayed ? ws_msb(k + 1) : ws_msb(k), sd_at(k, l, r),
               (k == spec_k) ? d : -1);
    end
  endtask

  task automatic read_words(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      int w = 0;
      while (!rx_ready && w < 1500) begin
        @(negedge clk);
        w++;
      end
      check(rx_ready, req, 32'(rx_ready), 32'd1);
      if (rx_ready) begin
        check((rd_data & exp_m[i]) == (exp_d[i] & exp_m[i]), req,
              32'(rd_data & exp_m[i]), 32'(exp_d[i] & exp_m[i]));
        check(rd_side == exp_s[i], "R7 channel side",
              32'(rd_side), 32'(exp_s[i]));
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        @(negedge clk);
      end
    end
  endtask

  task automatic restart(input logic delayed, input logic wide);
    @(negedge clk);
    cfg_en = 1'b0;
    repeat (3) @(negedge clk);
    cfg_philips = delayed;
    cfg_wide24 = wide;
    cfg_en = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_frame(input logic delayed, input logic wide,
                           input logic [31:0] l, input logic [31:0] r);
    int n;
    string req;
    restart(delayed, wide);
    if (!wide) begin
      n = 2;
      exp_d[0] = l[31:16]; exp_m[0] = 16'hFFFF; exp_s[0] = 1'b0;
      exp_d[1] = r[31:16]; exp_m[1] = 16'hFFFF; exp_s[1] = 1'b1;
    end else begin
      n = 4;
      exp_d[0] = l[31:16];        exp_m[0] = 16'hFFFF; exp_s[0] = 1'b0;
      exp_d[1] = {l[15:8], 8'h0}; exp_m[1] = 16'hFF00; exp_s[1] = 1'b0;
      exp_d[2] = r[31:16];        exp_m[2] = 16'hFFFF; exp_s[2] = 1'b1;
      exp_d[3] = {r[15:8], 8'h0}; exp_m[3] = 16'hFF00; exp_s[3] = 1'b1;
    end
    req = {delayed ? "R4" : "R3", wide ? " R6 wide" : " R5 narrow"};
    fork
      send_frame(delayed, l, r, -1, 0);
      read_words(n, req);
    join
    repeat (40) @(negedge clk);
    check(!rx_ready, wide ? "R6 no extra word" : "R5 no padding word",
          32'(rx_ready), 32'd0);
    check(!rx_overrun, "R9 no overrun when read in time",
          32'(rx_overrun), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] pats [6];
    pats[0] = 32'h8EAA33C5; pats[1] = 32'hFFFFFFFF; pats[2] = 32'h00000000;
    pats[3] = 32'hAAAA5555; pats[4] = 32'h12345678; pats[5] = 32'h80000001;

    repeat (5) @(negedge clk);
    check(!rx_ready && !rx_overrun && !irq, "R1 reset state",
          {29'd0, rx_ready, rx_overrun, irq}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!rx_ready && !rx_overrun, "R1 after reset",
          {30'd0, rx_ready, rx_overrun}, 32'd0);

    // R1: traffic while disabled is not accepted
    send_frame(1'b0, 32'hDEADBEEF, 32'h0BADF00D, -1, 0);
    repeat (20) @(negedge clk);
    check(!rx_ready, "R1 disabled ignores traffic", 32'(rx_ready), 32'd0);

    // R2 R3 R4 R5 R6 R7: sweep of alignments, sizes and data
    for (int m = 0; m < 4; m++) begin
      for (int p = 0; p < 6; p++) begin
        run_frame(m[0], m[1], pats[p],
                  {pats[p][15:0], pats[p][31:16]} ^ 32'h0F0F0F0F);
      end
    end

    // R8 R9 R10 R11: read pulse swept across the completion of the right word
    for (int d = 0; d < 7; d++) begin
      logic [31:0] a;
      logic [31:0] b;
      bit won;
      a = 32'hC3A50000 + 32'(d);
      b = 32'h5A3C0000 + 32'(d);
      won = (d <= 3);
      restart(1'b0, 1'b0);
      send_frame(1'b0, a, b, 49, d);
      repeat (20) @(negedge clk);
      check(rx_overrun == !won, won ? "R10 same-cycle read" : "R9 overrun",
            32'(rx_overrun), 32'(!won));
      check(rx_ready == won, won ? "R10 ready kept" : "R8 read clears",
            32'(rx_ready), 32'(won));
      check(rd_data == (won ? b[31:16] : a[31:16]),
            won ? "R10 new word" : "R9 old word kept",
            32'(rd_data), 32'(won ? b[31:16] : a[31:16]));
      check(rd_side == won, "R7 side of held word", 32'(rd_side), 32'(won));
      irq_en = 1'b1;
      @(negedge clk);
      check(irq == 1'b1, "R11 irq with flag set", 32'(irq), 32'd1);
      irq_en = 1'b0;
      @(negedge clk);
      check(irq == 1'b0, "R11 irq masked", 32'(irq), 32'd0);
    end

    // R9: overrun stays until disable
    repeat (10) @(negedge clk);
    check(rx_overrun, "R9 overrun sticky", 32'(rx_overrun), 32'd1);
    cfg_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(!rx_overrun && !rx_ready, "R1 disable clears flags",
          {30'd0, rx_ready, rx_overrun}, 32'd0);
    irq_en = 1'b1;
    @(negedge clk);
    check(!irq, "R11 no irq without flags", 32'(irq), 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule